// File: doc/BRIEF.md
# Complementary PWM Generator with Deadband and Trip

This block drives one complementary pair of PWM outputs from a 16-bit time-base counter. The counter either counts up and wraps (edge-aligned waveform) or counts up then down (centre-aligned waveform). The counter is compared against an active compare value to give a raw waveform. Two delay stages then derive the pair from it. Each stage holds off the rising edge of its output by a programmable number of clocks, so the two outputs are never high together.

Software writes the period and compare values through a small register write port into shadow copies. The shadow copies move into the active registers only at the counter's zero point. In centre-aligned mode they can optionally also move at the counter's turning point. A new frequency or duty cycle therefore never tears a period in progress. An active-low protection input passes through a synchronizer and a qualification filter. Once it is qualified low, the block sets a sticky trip flag that releases both output enables. That flag is visible in a status word and can raise a maskable interrupt. Only an explicit software clear releases it.

Top module: `cpwm_top`

## Requirements
- R1: While reset is asserted, `pwm_a` and `pwm_b` are 0, both output enables are 1, `irq` is 0 and `ctl_status` is all zero.
- R2: In edge-aligned mode (control bit 1 = 0, run bit 0 = 1) with period P, compare C and deadband D, the counter runs 0..P, and `pwm_a` is high for C−D clocks in each P+1-clock period when C−D > 0.
- R3: In centre-aligned mode (control bit 1 = 1), the counter runs 0..P..1 for a 2P-clock period, and `pwm_a` is high for 2C−1−D clocks per period.
- R4: `pwm_b` is the complement of the raw waveform with the same rising-edge delay: high for P+1−C−D clocks (edge-aligned) or 2P−2C+1−D clocks (centre-aligned) per period.
- R5: Deadband D is control bits 7:4. Each output rises D+1 clocks after its raw source rises and falls one clock after it falls. The two outputs are never high together, and a raw pulse of D clocks or fewer produces no output pulse.
- R6: Writes to the period (address 1) and compare (address 2) registers do not change the period in progress. They take effect from the next counter zero.
- R7: In centre-aligned mode with control bit 2 = 1, shadow values also load at the counter's top. With bit 2 = 0 they load only at zero, so a compare written during the up-count gives a pulse of C_old+C_new−1 clocks with bit 2 clear and 2·C_new−1 clocks with bit 2 set.
- R8: When `trip_n` is sampled low on two or more consecutive clocks, both output enables go to 0 within six clocks. A low lasting a single clock has no effect.
- R9: The trip state is sticky. It survives `trip_n` returning high and is cleared only by a write to address 3 with data bit 0 = 1 while the input is no longer qualified low. A clear while the input is still low has no effect.
- R10: `ctl_status` bit 8 shows the trip state and bit 9 the interrupt enable (control write bit 9). `irq` is high only while the trip state and the enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 period, 2 compare, 3 trip clear |
| wr_data | input | 16 | Write data |
| trip_n | input | 1 | Active-low protection input, asynchronous |
| pwm_a | output | 1 | Primary PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| pwm_oe_a | output | 1 | Output enable for `pwm_a`; 0 means high impedance |
| pwm_oe_b | output | 1 | Output enable for `pwm_b`; 0 means high impedance |
| irq | output | 1 | Trip interrupt, masked by control bit 9 |
| ctl_status | output | 16 | Control fields with trip state in bit 8 |

## Verification
The counter-step property assumes that the mode bit changes only while the run bit is low. It also assumes that no shorter period is loaded at the top of a centre-aligned count. The stimulus stops the counter before every reconfiguration and only lengthens the period while running. The trip property counts cycles from reset, so it ignores any protection-input level held during reset. The bench drives the protection input only on falling clock edges, so each low is seen for a whole number of clocks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int DB_W = 4;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_PRD = 2'd1;
  localparam logic [1:0] ADDR_CMP = 2'd2;
  localparam logic [1:0] ADDR_CLR = 2'd3;

  typedef struct packed {
    logic            irq_en;
    logic [DB_W-1:0] db;
    logic            ld_top;
    logic            sym;
    logic            run;
  } ctl_t;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sym,
  input  logic          ld_top,
  input  logic [CW-1:0] sh_prd,
  input  logic [CW-1:0] sh_cmp,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] act_cmp
);
  logic [CW-1:0] cnt_q, cnt_n, prd_q, prd_n, cmp_q, cmp_n;
  logic          up_q, up_n;
  logic          at_top, load;

  always_comb begin
    at_top = (cnt_q >= prd_q);
    load   = (cnt_q == '0) || (sym && ld_top && up_q && at_top);
    prd_n  = load ? sh_prd : prd_q;
    cmp_n  = load ? sh_cmp : cmp_q;
    cnt_n  = cnt_q;
    up_n   = up_q;
    if (!run) begin
      cnt_n = '0;
      up_n  = 1'b1;
    end else if (!sym) begin
      up_n  = 1'b1;
      cnt_n = at_top ? '0 : cnt_q + 1'b1;
    end else if (up_q) begin
      if (at_top) begin
        up_n  = 1'b0;
        cnt_n = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (cnt_q == '0) begin
      up_n  = 1'b1;
      cnt_n = (prd_q == '0) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      prd_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      prd_q <= prd_n;
      cmp_q <= cmp_n;
    end
  end

  assign cnt     = cnt_q;
  assign act_cmp = cmp_q;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DBW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw,
  input  logic [DBW-1:0] db,
  output logic           out_a,
  output logic           out_b
);
  localparam int NCH = 2;
  logic [NCH-1:0] src, dly;

  assign src = {~raw, raw};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DBW-1:0] c_q, c_n;
    logic           o_q, o_n;

    always_comb begin
      c_n = c_q;
      o_n = o_q;
      if (!src[g]) begin
        c_n = '0;
        o_n = 1'b0;
      end else if (c_q == db) begin
        o_n = 1'b1;
      end else begin
        c_n = c_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        o_q <= 1'b0;
      end else begin
        c_q <= c_n;
        o_q <= o_n;
      end
    end

    assign dly[g] = o_q;
  end

  assign out_a = dly[0];
  assign out_b = dly[1];
endmodule

// File: rtl/cpwm_trip.sv
module cpwm_trip #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_n,
  input  logic clr,
  output logic tripped
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);

  logic [1:0]    sync_q, sync_n;
  logic [QW-1:0] q_q, q_n;
  logic          lat_q, lat_n, lvl;

  always_comb begin
    sync_n = {sync_q[0], trip_n};
    lvl    = (q_q == QMAX);
    if (sync_q[1])
      q_n = '0;
    else if (!lvl)
      q_n = q_q + 1'b1;
    else
      q_n = q_q;
    lat_n = lvl || (lat_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      q_q    <= '0;
      lat_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      q_q    <= q_n;
      lat_q  <= lat_n;
    end
  end

  assign tripped = lat_q;
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CW   = 16,
  parameter int QUAL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trip_n,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          pwm_oe_a,
  output logic          pwm_oe_b,
  output logic          irq,
  output logic [CW-1:0] ctl_status
);
  ctl_t          ctl_q, ctl_n;
  logic [CW-1:0] sh_prd_q, sh_prd_n, sh_cmp_q, sh_cmp_n;
  logic [CW-1:0] cnt_w, act_cmp_w;
  logic          raw_q, raw_n;
  logic          trip_clr, tripped;

  always_comb begin
    ctl_n    = ctl_q;
    sh_prd_n = sh_prd_q;
    sh_cmp_n = sh_cmp_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTL: begin
          ctl_n.run    = wr_data[0];
          ctl_n.sym    = wr_data[1];
          ctl_n.ld_top = wr_data[2];
          ctl_n.db     = wr_data[4 +: DB_W];
          ctl_n.irq_en = wr_data[9];
        end
        ADDR_PRD: sh_prd_n = wr_data;
        ADDR_CMP: sh_cmp_n = wr_data;
        default: ;
      endcase
    end
    trip_clr = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
    raw_n    = ctl_q.run && (cnt_w < act_cmp_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sh_prd_q <= '0;
      sh_cmp_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      ctl_q    <= ctl_n;
      sh_prd_q <= sh_prd_n;
      sh_cmp_q <= sh_cmp_n;
      raw_q    <= raw_n;
    end
  end

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctl_q.run),
    .sym    (ctl_q.sym),
    .ld_top (ctl_q.ld_top),
    .sh_prd (sh_prd_q),
    .sh_cmp (sh_cmp_q),
    .cnt    (cnt_w),
    .act_cmp(act_cmp_w)
  );

  cpwm_deadband #(.DBW(DB_W)) u_db (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw_q),
    .db   (ctl_q.db),
    .out_a(pwm_a),
    .out_b(pwm_b)
  );

  cpwm_trip #(.QUAL(QUAL)) u_trip (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_n (trip_n),
    .clr    (trip_clr),
    .tripped(tripped)
  );

  always_comb begin
    ctl_status              = '0;
    ctl_status[0]           = ctl_q.run;
    ctl_status[1]           = ctl_q.sym;
    ctl_status[2]           = ctl_q.ld_top;
    ctl_status[4 +: DB_W]   = ctl_q.db;
    ctl_status[8]           = tripped;
    ctl_status[9]           = ctl_q.irq_en;
  end

  assign pwm_oe_a = !tripped;
  assign pwm_oe_b = !tripped;
  assign irq      = tripped && ctl_q.irq_en;
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          trip_n,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic          pwm_oe_a,
  input logic          pwm_oe_b,
  input logic          irq,
  input logic [CW-1:0] ctl_status,
  input logic [CW-1:0] cnt
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age_q <= '0;
    else if (age_q != 3'd7)
      age_q <= age_q + 3'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a && pwm_b)); // R5

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_status[0] && !ctl_status[1]) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == '0))); // R2

  AST_TRIP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 3'd7) && !$past(trip_n, 1) && !$past(trip_n, 2) && !$past(trip_n, 3)
      && !$past(trip_n, 4) && !$past(trip_n, 5)) |-> (!pwm_oe_a && !pwm_oe_b)); // R8

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe_a && !(wr_en && (wr_addr == 2'd3) && wr_data[0])) |=> !pwm_oe_a); // R9

  AST_IRQ_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!pwm_oe_b && ctl_status[9])); // R10
endmodule

bind cpwm_top cpwm_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .trip_n    (trip_n),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .pwm_oe_a  (pwm_oe_a),
  .pwm_oe_b  (pwm_oe_b),
  .irq       (irq),
  .ctl_status(ctl_status),
  .cnt       (cnt_w)
);

// File: tb/sim_cpwm_top.sv
`timescale 1ns/1ps
module sim_cpwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip_n = 1'b1;
  logic        pwm_a, pwm_b, pwm_oe_a, pwm_oe_b, irq;
  logic [15:0] ctl_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int qa[$];
  int qb[$];
  bit mon_en = 0;
  int cyc = 0;
  int rise_a, rise_b;
  bit seen_a, seen_b, skip_a, skip_b;
  logic pa_q = 1'b0, pb_q = 1'b0;
  int a_rises = 0;

  always #10 clk = ~clk;

  cpwm_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip_n(trip_n), .pwm_a(pwm_a), .pwm_b(pwm_b), .pwm_oe_a(pwm_oe_a),
    .pwm_oe_b(pwm_oe_b), .irq(irq), .ctl_status(ctl_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures each completed high pulse and scores it against the queue
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (pwm_a && !pa_q) begin rise_a = cyc; seen_a = 1; a_rises++; end
      if (!pwm_a && pa_q && seen_a) begin
        if (skip_a) skip_a = 0;
        else if (qa.size() > 0) chk("R2/R3/R6 pwm_a width", cyc - rise_a, qa.pop_front());
      end
      if (pwm_b && !pb_q) begin rise_b = cyc; seen_b = 1; end
      if (!pwm_b && pb_q && seen_b) begin
        if (skip_b) skip_b = 0;
        else if (qb.size() > 0) chk("R4/R6 pwm_b width", cyc - rise_b, qb.pop_front());
      end
    end
    pa_q = pwm_a;
    pb_q = pwm_b;
  end

  function automatic logic [15:0] ctlw(input bit run, input bit sym, input bit ld,
                                       input int db, input bit ie);
    return 16'((run ? 1 : 0) | (sym ? 2 : 0) | (ld ? 4 : 0) | ((db & 15) << 4) | (ie ? 512 : 0));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mon_start();
    seen_a = 0; seen_b = 0; skip_a = 1; skip_b = 1; a_rises = 0;
    mon_en = 1;
  endtask

  task automatic wait_empty(input string req);
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      if (qa.size() == 0 && qb.size() == 0) break;
    end
    n_chk++;
    if (qa.size() != 0 || qb.size() != 0) begin
      n_bad++;
      $display("FAIL %s: actual %0d pulses pending expected 0", req, qa.size() + qb.size());
      qa.delete(); qb.delete();
    end
  endtask

  task automatic stop_run();
    mon_en = 0;
    wr(2'd0, 16'h0000);
    repeat (30) @(negedge clk);
  endtask

  task automatic run_case(input string req, input bit sym, input int p, input int c,
                          input int d, input int na, input int ea, input int nb, input int eb);
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(c));
    wr(2'd0, ctlw(0, sym, 0, d, 0));
    repeat (20) @(negedge clk);
    mon_start();
    for (int i = 0; i < na; i++) qa.push_back(ea);
    for (int i = 0; i < nb; i++) qb.push_back(eb);
    wr(2'd0, ctlw(1, sym, 0, d, 0));
    wait_empty(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 pwm_b", int'(pwm_b), 0);
    chk("R1 oe_a", int'(pwm_oe_a), 1);
    chk("R1 oe_b", int'(pwm_oe_b), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 status", int'(ctl_status), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2, R4: edge-aligned widths
    run_case("R2 edge P9 C4 D1", 0, 9, 4, 1, 3, 3, 3, 5);
    stop_run();
    run_case("R2 edge P19 C10 D3", 0, 19, 10, 3, 3, 7, 3, 7);
    stop_run();
    // R3, R4: centre-aligned widths
    run_case("R3 centre P8 C3 D2", 1, 8, 3, 2, 3, 3, 3, 9);
    stop_run();
    run_case("R3 centre P12 C6 D0", 1, 12, 6, 0, 3, 11, 3, 13);
    stop_run();

    // R5: pulse no longer than deadband is suppressed on pwm_a
    run_case("R5 suppress P9 C3 D3", 0, 9, 3, 3, 0, 0, 3, 4);
    chk("R5 pwm_a rises with C equal to D", a_rises, 0);
    stop_run();

    // R6: shadow compare and period take effect at next zero
    run_case("R6 base P19 C2", 0, 19, 2, 0, 2, 2, 0, 0);
    wr(2'd2, 16'd6);
    qb.push_back(18); qb.push_back(14);
    qa.push_back(6);  qa.push_back(6);
    wait_empty("R6 compare reload");
    wr(2'd1, 16'd29);
    qb.push_back(14); qb.push_back(24);
    qa.push_back(6);
    wait_empty("R6 period reload");
    stop_run();

    // R7: centre-aligned reload at zero only vs also at top
    run_case("R7 no top load base", 1, 10, 3, 0, 2, 5, 0, 0);
    wr(2'd2, 16'd6);
    qa.push_back(8);
    wait_empty("R7 zero-only reload");
    stop_run();
    wr(2'd1, 16'd10);
    wr(2'd2, 16'd3);
    wr(2'd0, ctlw(0, 1, 1, 0, 0));
    repeat (20) @(negedge clk);
    mon_start();
    qa.push_back(5);
    wr(2'd0, ctlw(1, 1, 1, 0, 0));
    wait_empty("R7 top reload base");
    wr(2'd2, 16'd6);
    qa.push_back(11);
    wait_empty("R7 top reload");
    stop_run();

    // R8: single-clock glitch ignored
    @(negedge clk); trip_n = 1'b0;
    @(negedge clk); trip_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 glitch oe_a", int'(pwm_oe_a), 1);
    chk("R8 glitch status bit 8", int'(ctl_status[8]), 0);

    // R8, R10: qualified low trips, irq masked
    @(negedge clk); trip_n = 1'b0;
    repeat (3) @(negedge clk);
    trip_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 trip oe_a", int'(pwm_oe_a), 0);
    chk("R8 trip oe_b", int'(pwm_oe_b), 0);
    chk("R10 status bit 8", int'(ctl_status[8]), 1);
    chk("R10 irq masked", int'(irq), 0);

    // R9: sticky after input returns high
    repeat (10) @(negedge clk);
    chk("R9 sticky oe_a", int'(pwm_oe_a), 0);

    // R10: unmask
    wr(2'd0, ctlw(0, 0, 0, 0, 1));
    @(negedge clk);
    chk("R10 irq enabled", int'(irq), 1);
    chk("R10 status bit 9", int'(ctl_status[9]), 1);

    // R9: clear ignored while input still low
    @(negedge clk); trip_n = 1'b0;
    repeat (8) @(negedge clk);
    wr(2'd3, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R9 clear while low", int'(ctl_status[8]), 1);
    trip_n = 1'b1;
    repeat (6) @(negedge clk);
    wr(2'd3, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R9 cleared status", int'(ctl_status[8]), 0);
    chk("R9 cleared oe_a", int'(pwm_oe_a), 1);
    chk("R10 irq after clear", int'(irq), 0);

    finish_run();
  end
endmodule